// File: doc/BRIEF.md
# Burst Address Counter with Readback

This block is the address generator that sits in front of one port of a memory array. On every rising clock edge it applies one of five operations, chosen by three active-low controls: clear, load, hold, step or peek. It presents on `acc_addr` the address that the memory must use for the access in the current cycle. This is the value the counter takes at the coming edge, so a clear or a load costs no dead cycle. The counter spans the whole address space and wraps from the top address back to zero.

In peek mode the counter is frozen and the external address is ignored. If peek is held long enough, the counter value is returned on `rb_data` with `rb_valid` high, laid out for the port width selected on `width_sel`. A 9-bit port receives the address in two beats.

All pins are plain control and status signals. There is no stream handshake, because the block has no back-pressure to express. The counter produces a new access address every cycle, and readback data is a registered snapshot that stays valid for as long as peek is held.

Top module: `burst_addr_ctr`

## Requirements
- R1: With `cnt_clr_n` low, `acc_addr` is zero in the same cycle and the count is zero after the edge, whatever `adr_stb_n`, `cnt_en_n` and `ext_addr` are.
- R2: With `cnt_clr_n` high, `adr_stb_n` low and `cnt_en_n` low (load), `acc_addr` equals `ext_addr` in the same cycle and the count takes that value at the edge.
- R3: With `cnt_clr_n`, `adr_stb_n` and `cnt_en_n` all high (hold), `acc_addr` equals the count and the count is unchanged.
- R4: With `cnt_clr_n` high, `adr_stb_n` high and `cnt_en_n` low (step), `acc_addr` is the count plus one and the count takes that value. From the all-ones address it wraps to zero.
- R5: With `cnt_clr_n` high, `adr_stb_n` low and `cnt_en_n` high (peek), `ext_addr` is ignored, `acc_addr` equals the count and the count is unchanged.
- R6: For `width_sel` 00, 01 (both 36-bit) or 10 (18-bit), `rb_valid` is high after the second and every later consecutive peek edge. `rb_data` then carries the count on bits 3 upward, with all other bits zero.
- R7: For `width_sel` 11 (9-bit), `rb_valid` is high after the second consecutive peek edge, and `rb_data[8:0]` then carries count bits [ADDR_W-1:LO_W]. After the third and later consecutive peek edges, `rb_data[LO_W:1]` carries count bits [LO_W-1:0]. All other bits are zero.
- R8: After any edge whose operation is not peek, and after a single isolated peek edge, `rb_valid` is low and `rb_data` is zero.
- R9: While `rst_n` is low and right after it is released, the count is zero, `rb_valid` is low and `rb_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block's registers |
| cnt_clr_n | input | 1 | Active-low counter clear, highest priority |
| adr_stb_n | input | 1 | Active-low address strobe |
| cnt_en_n | input | 1 | Active-low count enable |
| ext_addr | input | ADDR_W | External address for load |
| width_sel | input | 2 | Port width: 00/01 36-bit, 10 18-bit, 11 9-bit |
| acc_addr | output | ADDR_W | Address for the current access |
| rb_data | output | DATA_W | Readback word carrying the count |
| rb_valid | output | 1 | Readback word valid |

## Verification
Random streams mix all five operations with random external addresses. Peek runs of one to four cycles separate the first-beat and second-beat readback timing from the isolated-peek case. Directed cases drive clear together with an active strobe and enable, which separates the priority order from a plain load. A load of the top address followed by a step shows whether the counter wraps or saturates. The width is switched between the 36, 18 and 9-bit settings, so the bench tells the single-beat layout apart from the two-beat split.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    OP_CLEAR = 3'd0,
    OP_LOAD  = 3'd1,
    OP_HOLD  = 3'd2,
    OP_PEEK  = 3'd3,
    OP_STEP  = 3'd4
  } bac_op_e;

  typedef enum logic [1:0] {
    WID_36  = 2'b00,
    WID_36B = 2'b01,
    WID_18  = 2'b10,
    WID_9   = 2'b11
  } bac_wid_e;

  localparam int RUN_W   = 2;
  localparam int RUN_MAX = 3;
  localparam int RB_LSB  = 3;
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic    clr_n,
  input  logic    stb_n,
  input  logic    en_n,
  output bac_op_e op
);
  // clear beats strobe, strobe beats enable
  always_comb begin
    if (!clr_n)     op = OP_CLEAR;
    else if (!stb_n) op = en_n ? OP_PEEK : OP_LOAD;
    else             op = en_n ? OP_HOLD : OP_STEP;
  end
endmodule

// File: rtl/bac_count.sv
module bac_count
  import bac_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bac_op_e           op,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] cnt_q
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // access address equals the value the counter takes at the edge
  always_comb begin
    unique case (op)
      OP_CLEAR: acc_addr = '0;
      OP_LOAD:  acc_addr = ext_addr;
      OP_STEP:  acc_addr = cnt_q + ONE;
      default:  acc_addr = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= acc_addr;
  end

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLEAR) |=> (cnt_q == '0));
  p_load_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (cnt_q == $past(ext_addr)));
  p_hold_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> $stable(cnt_q));
  p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (cnt_q == ADDR_W'($past(cnt_q) + ONE)));
  p_peek_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PEEK) |=> $stable(cnt_q));
endmodule

// File: rtl/bac_readback.sv
module bac_readback
  import bac_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int LO_W   = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              peek,
  input  logic [1:0]        width_sel,
  input  logic [ADDR_W-1:0] cnt,
  output logic              rb_valid,
  output logic [DATA_W-1:0] rb_data
);
  localparam int HI_W = ADDR_W - LO_W;

  logic [RUN_W-1:0]  run_q, run_nx;
  logic              vld_nx;
  logic [DATA_W-1:0] dat_nx;

  always_comb begin
    if (!peek)                      run_nx = '0;
    else if (run_q == RUN_W'(RUN_MAX)) run_nx = run_q;
    else                            run_nx = run_q + RUN_W'(1);
  end

  assign vld_nx = peek && (run_nx >= RUN_W'(2));

  always_comb begin
    dat_nx = '0;
    if (vld_nx) begin
      if (width_sel == WID_9) begin
        if (run_nx == RUN_W'(2)) dat_nx[HI_W-1:0]  = cnt[ADDR_W-1:LO_W];
        else                     dat_nx[LO_W:1]    = cnt[LO_W-1:0];
      end else begin
        dat_nx[RB_LSB +: ADDR_W] = cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      rb_valid <= 1'b0;
      rb_data  <= '0;
    end else begin
      run_q    <= run_nx;
      rb_valid <= vld_nx;
      rb_data  <= dat_nx;
    end
  end

  p_rb_after_peek_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> $past(peek));
  p_rb_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !peek |=> (!rb_valid && rb_data == '0));
  p_rb_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && $past(rb_valid) && $stable(width_sel) && width_sel != WID_9)
      |-> $stable(rb_data));
  p_rb_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_valid |-> (rb_data == '0));
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bac_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int LO_W   = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_clr_n,
  input  logic              adr_stb_n,
  input  logic              cnt_en_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [1:0]        width_sel,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] rb_data,
  output logic              rb_valid
);
  bac_op_e           op;
  logic [ADDR_W-1:0] cnt_q;

  bac_decode u_dec (
    .clr_n (cnt_clr_n),
    .stb_n (adr_stb_n),
    .en_n  (cnt_en_n),
    .op    (op)
  );

  bac_count #(.ADDR_W(ADDR_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ext_addr (ext_addr),
    .acc_addr (acc_addr),
    .cnt_q    (cnt_q)
  );

  bac_readback #(.ADDR_W(ADDR_W), .LO_W(LO_W), .DATA_W(DATA_W)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .peek      (op == OP_PEEK),
    .width_sel (width_sel),
    .cnt       (cnt_q),
    .rb_valid  (rb_valid),
    .rb_data   (rb_data)
  );

  p_clear_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr_n |=> (!rb_valid && $past(acc_addr) == '0));
endmodule

// File: tb/burst_addr_ctr_tb.sv
`timescale 1ns/1ps
module burst_addr_ctr_tb;
  localparam int AW = 15;
  localparam int LW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1, stb_n = 1'b1, en_n = 1'b1;
  logic [AW-1:0] ext = '0;
  logic [1:0] wid = 2'b00;
  logic [AW-1:0] acc;
  logic [DW-1:0] rbd;
  logic rbv;

  int total = 0, bad = 0;
  logic done = 1'b0;

  logic [AW-1:0] m_cnt = '0;
  int m_run = 0;
  logic m_rbv = 1'b0;
  logic [DW-1:0] m_rbd = '0;

  always #2.5 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(AW), .LO_W(LW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_clr_n(clr_n), .adr_stb_n(stb_n),
    .cnt_en_n(en_n), .ext_addr(ext), .width_sel(wid),
    .acc_addr(acc), .rb_data(rbd), .rb_valid(rbv)
  );

  function automatic logic [AW-1:0] exp_acc(logic c, logic s, logic e,
                                            logic [AW-1:0] n, logic [AW-1:0] x);
    if (!c) return '0;
    if (!s) return e ? n : x;
    return e ? n : AW'(n + 1);
  endfunction

  function automatic string op_tag(logic c, logic s, logic e);
    if (!c) return "R1";
    if (!s) return e ? "R5" : "R2";
    return e ? "R3" : "R4";
  endfunction

  function automatic logic [DW-1:0] exp_rb(logic [1:0] w, int run, logic [AW-1:0] n);
    logic [DW-1:0] d = '0;
    if (w == 2'b11) begin
      if (run == 2) d[AW-LW-1:0] = n[AW-1:LW];
      else          d[LW:1] = n[LW-1:0];
    end else d[3 +: AW] = n;
    return d;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic c, logic s, logic e, logic [AW-1:0] x);
    logic peek;
    logic [AW-1:0] ea;
    @(negedge clk);
    clr_n = c; stb_n = s; en_n = e; ext = x;
    #1;
    ea = exp_acc(c, s, e, m_cnt, x);
    chk(op_tag(c, s, e), "acc_addr", 64'(acc), 64'(ea));
    if (m_rbv) begin
      chk((wid == 2'b11) ? "R7" : "R6", "rb_valid", 64'(rbv), 64'(m_rbv));
      chk((wid == 2'b11) ? "R7" : "R6", "rb_data", 64'(rbd), 64'(m_rbd));
    end else begin
      chk("R8", "rb_valid", 64'(rbv), 64'(m_rbv));
      chk("R8", "rb_data", 64'(rbd), 64'(m_rbd));
    end
    @(posedge clk);
    peek = c && !s && e;
    m_cnt = ea;
    m_run = peek ? ((m_run >= 3) ? 3 : m_run + 1) : 0;
    m_rbv = peek && (m_run >= 2);
    m_rbd = m_rbv ? exp_rb(wid, m_run, m_cnt) : '0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "rb_valid in reset", 64'(rbv), 64'd0);
    chk("R9", "rb_data in reset", 64'(rbd), 64'd0);
    rst_n = 1'b1;
    #1;
    chk("R9", "acc_addr after reset", 64'(acc), 64'd0);
    // R2 then R1 priority over an active load pattern
    cyc(1, 0, 0, 15'h1234);
    cyc(0, 0, 0, 15'h5555);
    cyc(0, 0, 1, 15'h2222);
    // R4 wrap from all ones
    cyc(1, 0, 0, '1);
    cyc(1, 1, 0, 15'h0101);
    cyc(1, 1, 0, 15'h0101);
    // peek runs in each width (R6, R7, R8), external address ignored (R5)
    for (int w = 0; w < 4; w++) begin
      wid = 2'(w);
      cyc(1, 0, 0, 15'h6ABC);
      cyc(1, 0, 1, 15'h0000);   // isolated peek
      cyc(1, 1, 1, 15'h7FFF);
      for (int k = 0; k < 4; k++) cyc(1, 0, 1, AW'($urandom));
      cyc(1, 1, 1, 15'h0);
    end
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int kind;
      if (i % 200 == 0) begin
        cyc(1, 1, 1, '0);
        wid = 2'($urandom);
      end
      kind = int'($urandom % 9);
      case (kind)
        0: cyc(0, 1'($urandom), 1'($urandom), AW'($urandom));
        1, 2: cyc(1, 0, 0, ($urandom % 8 == 0) ? '1 : AW'($urandom));
        3: cyc(1, 1, 1, AW'($urandom));
        4, 5: cyc(1, 1, 0, AW'($urandom));
        default: begin
          int len = 1 + int'($urandom % 4);
          for (int k = 0; k < len; k++) cyc(1, 0, 1, AW'($urandom));
        end
      endcase
    end
    cyc(1, 1, 1, '0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule